// File: doc/BRIEF.md
# Codec Power-State Sequencer

This controller sets the power state of a dual-channel voice codec. A free-running system clock watches two slow external strobes: the PCM bit clock and the transmit frame sync. It also watches a power-up request pin and a lock indication from the PLL. From these inputs it drives the enables for the analog reference, the analog signal path and the transmit feedback amplifier. It also drives the mute that holds the receive outputs at signal ground, and the enable of the open-drain PCM outputs.

A low power-up request stops everything. If either strobe stays at one level, high or low, for longer than its detection window, the block drops to a save state. In that state only the reference stays on. Once both strobes toggle again and power-up is high, the block starts a two-phase wake-up. It first waits for PLL lock. It then holds the outputs muted for a fixed 1 ms, counted in system-clock cycles, and only after that unmutes and releases the PCM outputs. If lock does not arrive within the timeout (10 ms by default), a sticky error flag is set and the outputs stay muted.

The states and their codes on `state_o` are POWER_DOWN = 0, POWER_SAVE = 1, WAIT_LOCK = 2, MUTE = 3 and ACTIVE = 4. The transitions are:
- any state to POWER_DOWN when power-up is low;
- WAIT_LOCK, MUTE or ACTIVE to POWER_SAVE when a strobe is lost;
- POWER_DOWN or POWER_SAVE to POWER_SAVE when power-up is high but a strobe is missing;
- POWER_DOWN or POWER_SAVE to WAIT_LOCK when power-up is high and both strobes are alive;
- WAIT_LOCK to MUTE on lock;
- MUTE to ACTIVE when the mute time has elapsed.

Top module: `codec_pwr_seq`

## Requirements
- R1: After reset the state is POWER_DOWN (`state_o` = 0). In that state `ref_en_o`, `analog_en_o`, `pcm_oe_o`, `txfb_en_o` and `lock_err_o` are 0 and `rx_mute_o` is 1.
- R2: When `pwr_up_i` is low, the block reaches POWER_DOWN from any state within SYNC_STAGES+1 cycles and stays there.
- R3: When `pwr_up_i` is high and either strobe has shown no edge for its window, the state is POWER_SAVE (1). In that state `ref_en_o` is 1, `analog_en_o` and `pcm_oe_o` are 0, and `rx_mute_o` is 1.
- R4: A strobe counts as lost whether it is stuck high or stuck low. A strobe whose gaps between edges are shorter than its window never counts as lost.
- R5: When power-up is high and both strobes toggle, the block leaves POWER_DOWN or POWER_SAVE for WAIT_LOCK (2). In WAIT_LOCK `analog_en_o` is 1, `rx_mute_o` is 1 and `pcm_oe_o` is 0.
- R6: Once lock is seen in WAIT_LOCK, the state is MUTE (3) for exactly SYS_CLK_HZ/1000*MUTE_US/1000 cycles, with outputs muted and `pcm_oe_o` at 0. It then becomes ACTIVE (4).
- R7: `pcm_oe_o` is 1 and `rx_mute_o` is 0 only in ACTIVE. ACTIVE is entered only from MUTE.
- R8: Loss of a strobe in WAIT_LOCK, MUTE or ACTIVE leads to POWER_SAVE. When the strobes return, the block restarts at WAIT_LOCK and passes through a full MUTE period again.
- R9: If WAIT_LOCK lasts SYS_CLK_HZ/1000*LOCK_TIMEOUT_US/1000 cycles without lock, `lock_err_o` rises exactly that many cycles after WAIT_LOCK was entered. The flag stays set until reset. While it is set, MUTE and ACTIVE are never entered.
- R10: `txfb_en_o` is 1 in WAIT_LOCK, MUTE and ACTIVE. In POWER_DOWN and POWER_SAVE it is 0, and `txfb_pull_o` is then 1 if TXFB_WEAK_PULL = 1 (weak tie to analog ground) or 0 for high impedance.
- R11: `ref_en_o` is 0 only in POWER_DOWN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up_i | input | 1 | Power-up request; low forces power down |
| bclk_i | input | 1 | PCM bit clock, monitored for activity |
| fsync_tx_i | input | 1 | Transmit frame sync, monitored for activity |
| pll_locked_i | input | 1 | PLL lock indication |
| state_o | output | 3 | Current state code |
| ref_en_o | output | 1 | Analog reference enable |
| analog_en_o | output | 1 | Analog signal path enable |
| rx_mute_o | output | 1 | Hold receive outputs at signal ground |
| pcm_oe_o | output | 1 | Enable of open-drain PCM outputs |
| txfb_en_o | output | 1 | Transmit feedback amplifier enable |
| txfb_pull_o | output | 1 | Weak pull of transmit feedback to analog ground |
| lock_err_o | output | 1 | Sticky PLL lock timeout flag |

## Verification
A wrong state shows at once on `state_o` and on the enable outputs, because both decode the same state register in the cycle it changes. A mute counter that is off by even one cycle shows as a MUTE dwell that differs from the exact count. The same holds for the lock timeout, since the error flag would rise one cycle early or late. A strobe detector that is too slow or too eager shows as a state that either leaves ACTIVE while the strobes still toggle, or is still ACTIVE a few cycles after the window should have expired.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

    typedef enum logic [2:0] {
        ST_POWER_DOWN = 3'd0,
        ST_POWER_SAVE = 3'd1,
        ST_WAIT_LOCK  = 3'd2,
        ST_MUTE       = 3'd3,
        ST_ACTIVE     = 3'd4
    } pwr_state_e;

    typedef struct packed {
        logic ref_en;
        logic analog_en;
        logic rx_mute;
        logic pcm_oe;
        logic txfb_en;
        logic txfb_pull;
    } pwr_ctrl_t;

endpackage

// File: rtl/cps_bit_sync.sv
module cps_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cps_activity_watch.sv
module cps_activity_watch #(
    parameter int WINDOW      = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic alive_o
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] WIN = CW'(WINDOW);

    logic          sig_s;
    logic          prev_q;
    logic          edge_w;
    logic [CW-1:0] cnt_q;

    cps_bit_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (sig_i),
        .q_o  (sig_s)
    );

    assign edge_w = sig_s ^ prev_q;

    // Count cycles since the last edge of either polarity; saturate at the window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= WIN;
        end else begin
            prev_q <= sig_s;
            if (edge_w)          cnt_q <= '0;
            else if (cnt_q < WIN) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign alive_o = (cnt_q < WIN);

    // R4
    win_sat_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= WIN);
    // R4
    edge_alive_chk: assert property (@(posedge clk) disable iff (!rst_n) edge_w |=> alive_o);
endmodule

// File: rtl/cps_phase_timer.sv
module cps_phase_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    output logic [TW-1:0] cnt_o
);
    localparam logic [TW-1:0] TOP = {TW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_o <= '0;
        else if (clear_i)       cnt_o <= '0;
        else if (cnt_o != TOP)  cnt_o <= cnt_o + 1'b1;
    end

    // R6
    timer_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> cnt_o >= $past(cnt_o));
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
    import codec_pwr_pkg::*;
#(
    parameter int SYS_CLK_HZ      = 50_000_000,
    parameter int MUTE_US         = 1000,
    parameter int LOCK_TIMEOUT_US = 10000,
    parameter int BCLK_WINDOW     = 1024,
    parameter int FSYNC_WINDOW    = 8192,
    parameter int SYNC_STAGES     = 2,
    parameter bit TXFB_WEAK_PULL  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_up_i,
    input  logic       bclk_i,
    input  logic       fsync_tx_i,
    input  logic       pll_locked_i,
    output logic [2:0] state_o,
    output logic       ref_en_o,
    output logic       analog_en_o,
    output logic       rx_mute_o,
    output logic       pcm_oe_o,
    output logic       txfb_en_o,
    output logic       txfb_pull_o,
    output logic       lock_err_o
);
    localparam int CYC_PER_MS = SYS_CLK_HZ / 1000;
    localparam int MUTE_CYC   = CYC_PER_MS * MUTE_US / 1000;
    localparam int LOCK_CYC   = CYC_PER_MS * LOCK_TIMEOUT_US / 1000;
    localparam int MAX_CYC    = (LOCK_CYC > MUTE_CYC) ? LOCK_CYC : MUTE_CYC;
    localparam int TW         = $clog2(MAX_CYC + 1) + 1;
    localparam logic [TW-1:0] MUTE_LAST = TW'(MUTE_CYC - 1);
    localparam logic [TW-1:0] LOCK_LAST = TW'(LOCK_CYC - 1);

    pwr_state_e    state_q, state_d;
    logic          err_q, err_d;
    logic          pwr_s, lock_s;
    logic          bclk_alive, fs_alive, clocks_ok;
    logic [TW-1:0] tmr;
    logic          tmr_clr;
    pwr_ctrl_t     ctrl;

    cps_bit_sync #(.STAGES(SYNC_STAGES)) i_pwr_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pwr_up_i), .q_o(pwr_s)
    );
    cps_bit_sync #(.STAGES(SYNC_STAGES)) i_lock_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pll_locked_i), .q_o(lock_s)
    );
    cps_activity_watch #(.WINDOW(BCLK_WINDOW), .SYNC_STAGES(SYNC_STAGES)) i_bclk_watch (
        .clk(clk), .rst_n(rst_n), .sig_i(bclk_i), .alive_o(bclk_alive)
    );
    cps_activity_watch #(.WINDOW(FSYNC_WINDOW), .SYNC_STAGES(SYNC_STAGES)) i_fs_watch (
        .clk(clk), .rst_n(rst_n), .sig_i(fsync_tx_i), .alive_o(fs_alive)
    );

    assign clocks_ok = bclk_alive & fs_alive;
    assign tmr_clr   = (state_d != state_q);

    cps_phase_timer #(.TW(TW)) i_timer (
        .clk(clk), .rst_n(rst_n), .clear_i(tmr_clr), .cnt_o(tmr)
    );

    // Next-state logic: power-up low dominates, then strobe loss, then the wake sequence
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        if (!pwr_s) begin
            state_d = ST_POWER_DOWN;
        end else if (!clocks_ok) begin
            state_d = ST_POWER_SAVE;
        end else begin
            unique case (state_q)
                ST_POWER_DOWN, ST_POWER_SAVE: state_d = ST_WAIT_LOCK;
                ST_WAIT_LOCK: begin
                    if (lock_s && !err_q)     state_d = ST_MUTE;
                    else if (tmr == LOCK_LAST) err_d = 1'b1;
                end
                ST_MUTE: begin
                    if (tmr == MUTE_LAST) state_d = ST_ACTIVE;
                end
                ST_ACTIVE: state_d = ST_ACTIVE;
                default:   state_d = ST_POWER_DOWN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWER_DOWN;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    // Output decode
    always_comb begin
        ctrl = '0;
        unique case (state_q)
            ST_POWER_DOWN: begin
                ctrl.rx_mute   = 1'b1;
                ctrl.txfb_pull = TXFB_WEAK_PULL;
            end
            ST_POWER_SAVE: begin
                ctrl.ref_en    = 1'b1;
                ctrl.rx_mute   = 1'b1;
                ctrl.txfb_pull = TXFB_WEAK_PULL;
            end
            ST_WAIT_LOCK, ST_MUTE: begin
                ctrl.ref_en    = 1'b1;
                ctrl.analog_en = 1'b1;
                ctrl.rx_mute   = 1'b1;
                ctrl.txfb_en   = 1'b1;
            end
            ST_ACTIVE: begin
                ctrl.ref_en    = 1'b1;
                ctrl.analog_en = 1'b1;
                ctrl.pcm_oe    = 1'b1;
                ctrl.txfb_en   = 1'b1;
            end
            default: ctrl.rx_mute = 1'b1;
        endcase
    end

    assign state_o     = state_q;
    assign ref_en_o    = ctrl.ref_en;
    assign analog_en_o = ctrl.analog_en;
    assign rx_mute_o   = ctrl.rx_mute;
    assign pcm_oe_o    = ctrl.pcm_oe;
    assign txfb_en_o   = ctrl.txfb_en;
    assign txfb_pull_o = ctrl.txfb_pull;
    assign lock_err_o  = err_q;

    // R2
    pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |=> state_q == ST_POWER_DOWN);
    // R7
    active_from_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && $past(state_q) != ST_ACTIVE) |-> $past(state_q) == ST_MUTE);
    // R6
    mute_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && $past(state_q) == ST_MUTE) |-> $past(tmr) == MUTE_LAST);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R9
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (state_q != ST_MUTE && state_q != ST_ACTIVE));
    // R8
    save_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_POWER_SAVE && state_q != ST_POWER_SAVE)
            |-> (state_q == ST_WAIT_LOCK || state_q == ST_POWER_DOWN));
endmodule

// File: tb/test_codec_pwr_seq.sv
`timescale 1ns/1ps
module test_codec_pwr_seq;
    localparam int SYS_HZ   = 1_000_000;
    localparam int MUTE_N   = 1000;
    localparam int LOCK_N   = 10000;
    localparam int BWIN     = 32;
    localparam int FWIN     = 256;
    localparam int SETTLE   = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_up = 1'b0, bclk = 1'b0, fsync = 1'b0, locked = 1'b0;
    logic b_run = 1'b0, f_run = 1'b0, b_lvl = 1'b0, f_lvl = 1'b0;
    logic [2:0] state;
    logic ref_en, analog_en, rx_mute, pcm_oe, txfb_en, txfb_pull, lock_err;
    int checks = 0, errors = 0;
    int bdiv = 0, fdiv = 0;
    bit done = 0;

    always #10 clk = ~clk;

    codec_pwr_seq #(
        .SYS_CLK_HZ(SYS_HZ), .MUTE_US(1000), .LOCK_TIMEOUT_US(10000),
        .BCLK_WINDOW(BWIN), .FSYNC_WINDOW(FWIN), .SYNC_STAGES(2), .TXFB_WEAK_PULL(1'b1)
    ) i_codec_pwr_seq (
        .clk(clk), .rst_n(rst_n), .pwr_up_i(pwr_up), .bclk_i(bclk), .fsync_tx_i(fsync),
        .pll_locked_i(locked), .state_o(state), .ref_en_o(ref_en), .analog_en_o(analog_en),
        .rx_mute_o(rx_mute), .pcm_oe_o(pcm_oe), .txfb_en_o(txfb_en),
        .txfb_pull_o(txfb_pull), .lock_err_o(lock_err)
    );

    // Strobe generators: bit clock toggles every 3 cycles, frame sync pulses every 100
    always @(negedge clk) begin
        if (b_run) begin
            bdiv = bdiv + 1;
            if (bdiv >= 3) begin bdiv = 0; bclk = ~bclk; end
        end else bclk = b_lvl;
        if (f_run) begin
            fdiv = (fdiv + 1) % 100;
            fsync = (fdiv == 0);
        end else fsync = f_lvl;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_ctrl(input int st);
        case (st)
            0: return 6'b001001;
            1: return 6'b101001;
            2, 3: return 6'b111010;
            4: return 6'b110110;
            default: return 6'b000000;
        endcase
    endfunction

    function automatic logic [5:0] got_ctrl();
        return {ref_en, analog_en, rx_mute, pcm_oe, txfb_en, txfb_pull};
    endfunction

    task automatic check_state(input string req, input int exp);
        check(req, int'(state), exp);
        check(req, int'(got_ctrl()), int'(exp_ctrl(exp)));
    endtask

    task automatic wait_state(input int st, input int limit);
        for (int i = 0; i < limit && int'(state) != st; i++) cyc(1);
    endtask

    initial begin : main
        int k;
        int prev, exp, age;
        bit p, b, f;
        void'($urandom(32'd20250611));
        cyc(3);
        // R1: reset state
        check_state("R1", 0);
        check("R1", int'(lock_err), 0);
        rst_n = 1'b1;
        cyc(5);
        check_state("R1", 0);

        // R3: powered but no strobes
        pwr_up = 1'b1;
        cyc(6);
        check_state("R3", 1);
        check("R11", int'(ref_en), 1);

        // R5: strobes run, no lock yet
        b_run = 1; f_run = 1;
        cyc(150);
        check_state("R5", 2);
        check("R10", int'(txfb_en), 1);

        // R6: exact mute dwell, then active
        locked = 1'b1;
        wait_state(3, 50);
        k = 0;
        while (int'(state) == 3 && k < 5000) begin cyc(1); k++; end
        check("R6", k, MUTE_N);
        check_state("R6", 4);
        check("R7", int'(pcm_oe), 1);

        // R4: bit clock stuck high; still active within window, save after it
        b_run = 0; b_lvl = 1;
        cyc(BWIN / 2);
        check_state("R4", 4);
        cyc(BWIN + 8);
        check_state("R3", 1);
        // R8: restart passes through a full mute again
        b_run = 1;
        wait_state(2, 50);
        check("R8", int'(state), 2);
        wait_state(3, 50);
        k = 0;
        while (int'(state) == 3 && k < 5000) begin cyc(1); k++; end
        check("R8", k, MUTE_N);
        check_state("R8", 4);

        // R4: frame sync stuck low, toggling strobe keeps it active meanwhile
        cyc(3 * FWIN);
        check_state("R4", 4);
        f_run = 0; f_lvl = 0;
        cyc(FWIN + 110);
        check_state("R4", 1);
        f_run = 1;
        wait_state(3, 300);
        check_state("R8", 3);

        // R2: power-up low during mute
        pwr_up = 1'b0;
        cyc(3);
        check_state("R2", 0);
        check("R11", int'(ref_en), 0);
        cyc(20);
        check_state("R2", 0);

        // Random phase with lock present
        pwr_up = 1'b1;
        cyc(SETTLE);
        prev = int'(state);
        age = 0;
        if (prev == 3) age = 1;
        for (int it = 0; it < 30; it++) begin
            p = ($urandom % 4) != 0;
            b = ($urandom % 3) != 0;
            f = ($urandom % 3) != 0;
            b_lvl = $urandom % 2;
            f_lvl = $urandom % 2;
            pwr_up = p; b_run = b; f_run = f;
            cyc(SETTLE);
            if (!p) exp = 0;
            else if (!(b && f)) exp = 1;
            else if (prev == 4) exp = 4;
            else if (prev == 3) begin age++; exp = (age >= 3) ? 4 : 3; end
            else begin age = 1; exp = 3; end
            if (exp != 3) age = 0;
            check_state("R3 R5 R6 random", exp);
            prev = exp;
        end

        // R9: lock timeout
        locked = 1'b0;
        pwr_up = 1'b0;
        cyc(10);
        b_run = 1; f_run = 1; pwr_up = 1'b1;
        wait_state(2, 300);
        k = 0;
        while (!lock_err && k < LOCK_N + 100) begin cyc(1); k++; end
        check("R9", k, LOCK_N);
        check_state("R9", 2);
        locked = 1'b1;
        cyc(50);
        check("R9", int'(state), 2);
        check("R9", int'(rx_mute), 1);
        pwr_up = 1'b0;
        cyc(10);
        check("R9", int'(lock_err), 1);
        // R10: weak pull returns when the amplifier is off
        check("R10", int'(txfb_pull), 1);
        check("R10", int'(txfb_en), 0);
        rst_n = 1'b0;
        cyc(2);
        check("R9", int'(lock_err), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule